// File: doc/BRIEF.md
# Link Crossing Capture and Pattern Replay Buffer

This block sits in line with one received trigger link that delivers one word per bunch crossing: an 8-bit tower energy plus a small group of feature bits. In normal operation it forwards the live word downstream with one register of delay. It can also record a run of 256 consecutive crossings into an internal buffer, aligned to the orbit marker, or it can replace the live stream with buffered test patterns.

A crossing counter is cleared by the orbit marker and wraps by itself at the orbit length. Replay can run in two ways. In one-shot mode the buffer plays once per orbit from crossing 0 and sends zeros for the rest of the orbit. In looping mode the buffer replays back to back every 256 crossings. A host register port selects the mode and reads or writes the buffer. Buffer access is refused while the block is recording or replaying.

Top module: `linkReplayBuf`

## Requirements
- R1: After reset the output word is zero, the mode is pass-through (code 0), the capture-complete flag is low and the access-error flag is low.
- R2: In pass-through (code 0) and recording (code 1) modes, the output energy and feature bits equal the live input of the previous cycle.
- R3: A crossing with the orbit marker high is crossing 0. Without a marker the counter steps once per cycle and wraps from ORBIT_LEN-1 back to 0.
- R4: After mode 1 is written, recording starts on the first orbit marker seen in a later cycle. Buffer entry k receives the live word of crossing k, for k = 0..255. A marker in the same cycle as the mode write does not start recording.
- R5: The capture-complete flag rises in the cycle after entry 255 is written. It stays high until the mode register is written again, and later markers do not start another recording.
- R6: In one-shot mode (code 2), the output in the cycle after crossing b is buffer entry b when b < 256, and zero energy with cleared feature bits otherwise.
- R7: In looping mode (code 3), the output in the cycle after crossing b is buffer entry b mod 256.
- R8: In pass-through mode, a host write with hostAddr[8]=0 stores hostWdata at entry hostAddr[7:0]. A host read returns that entry on hostRdata one cycle later. Word layout: bits [7:0] energy, bits [11:8] feature bits.
- R9: In any mode other than pass-through, a host buffer read or write raises hostErr in the next cycle. The write leaves the buffer unchanged and the read returns zero.
- R10: hostAddr[8]=1 selects the mode register. A write loads hostWdata[1:0] as the mode. A read returns the mode in bits [1:0] and the capture-complete flag in bit 2, one cycle later, in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rstN | input | 1 | Asynchronous active-low reset |
| orbitMark | input | 1 | Orbit marker; high on crossing 0 |
| liveEnergy | input | 8 | Live tower energy |
| liveFeat | input | 4 | Live feature and fine-grain bits |
| outEnergy | output | 8 | Downstream tower energy |
| outFeat | output | 4 | Downstream feature bits |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | 9 | Bit 8 selects the mode register; bits 7:0 select the buffer entry |
| hostWdata | input | 12 | Host write data |
| hostRdata | output | 12 | Host read data, valid one cycle after a read |
| hostErr | output | 1 | Buffer access refused in the previous cycle |
| captureDone | output | 1 | Recording of 256 crossings complete |

## Verification
On every cycle, the embedded properties check the following:
- a marker restarts the crossing count;
- the complete flag rises only right after the last buffer entry is recorded;
- a refused access raises the error flag;
- recording and host writes never contend for the buffer write port;
- the output follows the live word or goes to zero as the selected source demands.

Only the bench scenarios show which data actually lands in the buffer and comes back:
- the contents of a recording and its alignment to the marker;
- that a refused write left the entry intact;
- that one-shot replay resumes after the counter wraps with no marker;
- that looping replay realigns when a marker arrives mid-loop.

// File: rtl/lrbPkg.sv
`timescale 1ns/1ps
package lrbPkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_CAP  = 2'd1,
    MODE_ONCE = 2'd2,
    MODE_LOOP = 2'd3
  } lrbMode_e;

  typedef enum logic [1:0] {
    SEL_LIVE = 2'd0,
    SEL_MEM  = 2'd1,
    SEL_ZERO = 2'd2
  } lrbSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    capWr;
    logic    hostWrMem;
    logic    hostRdMem;
    logic    hostRdReg;
    lrbSel_e sel;
  } lrbStrb_t;
endpackage

// File: rtl/lrbCtrl.sv
`timescale 1ns/1ps
module lrbCtrl
  import lrbPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ORBIT_LEN = 3564
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              orbitMark,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              hostRegSel,
  input  logic [1:0]        hostModeData,
  output lrbStrb_t          strb,
  output logic [ADDR_W-1:0] capAddr,
  output logic [ADDR_W-1:0] playAddr,
  output logic [2:0]        regVal,
  output logic              hostErr,
  output logic              capDone
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BX_W  = $clog2(ORBIT_LEN);

  lrbMode_e          mode;
  logic              armed, capOn, done;
  logic [ADDR_W-1:0] capIdx;
  logic [BX_W-1:0]   bxCnt, bxNow, bxNext;
  logic              memAcc, modeWr, capStart, capWr, isPass;
  lrbSel_e           selC;

  always_comb begin
    bxNow    = orbitMark ? '0 : bxCnt;
    bxNext   = (bxNow == BX_W'(ORBIT_LEN - 1)) ? '0 : bxNow + 1'b1;
    memAcc   = (hostWr || hostRd) && !hostRegSel;
    modeWr   = hostWr && hostRegSel;
    isPass   = (mode == MODE_PASS);
    capStart = (mode == MODE_CAP) && armed && orbitMark;
    capWr    = (mode == MODE_CAP) && (capStart || capOn);
    capAddr  = capStart ? '0 : capIdx;
    playAddr = bxNow[ADDR_W-1:0];
    case (mode)
      MODE_ONCE: selC = (bxNow < BX_W'(DEPTH)) ? SEL_MEM : SEL_ZERO;
      MODE_LOOP: selC = SEL_MEM;
      default:   selC = SEL_LIVE;
    endcase
    strb.capWr     = capWr;
    strb.hostWrMem = hostWr && !hostRegSel && isPass;
    strb.hostRdMem = hostRd && !hostRegSel && isPass;
    strb.hostRdReg = hostRd && hostRegSel;
    strb.sel       = selC;
    regVal         = {done, mode};
    capDone        = done;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= MODE_PASS;
      armed   <= 1'b0;
      capOn   <= 1'b0;
      capIdx  <= '0;
      done    <= 1'b0;
      bxCnt   <= '0;
      hostErr <= 1'b0;
    end else begin
      bxCnt   <= bxNext;
      hostErr <= memAcc && !isPass;
      if (modeWr) begin
        mode   <= lrbMode_e'(hostModeData);
        armed  <= (hostModeData == MODE_CAP);
        done   <= 1'b0;
        capOn  <= 1'b0;
        capIdx <= '0;
      end else if (capWr) begin
        armed <= 1'b0;
        if (capAddr == '1) begin
          capOn <= 1'b0;
          done  <= 1'b1;
        end else begin
          capOn  <= 1'b1;
          capIdx <= capAddr + 1'b1;
        end
      end
    end
  end

  // R3: the crossing after a marker is crossing 1
  p_bx_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    orbitMark |=> (bxCnt == BX_W'(1)));

  // R5: completion follows only the last recorded entry
  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(capOn) && ($past(capIdx) == '1)));

  // R9: refused access is flagged
  p_err_outside_pass_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memAcc && (mode != MODE_PASS)) |=> hostErr);
endmodule

// File: rtl/lrbData.sv
`timescale 1ns/1ps
module lrbData
  import lrbPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  lrbStrb_t          strb,
  input  logic [ADDR_W-1:0] capAddr,
  input  logic [ADDR_W-1:0] playAddr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWdata,
  input  logic [WORD_W-1:0] liveWord,
  input  logic [2:0]        regVal,
  output logic [WORD_W-1:0] outWord,
  output logic [WORD_W-1:0] hostRdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              wrEn;
  logic [ADDR_W-1:0] wrAddr;
  logic [WORD_W-1:0] wrData;

  always_comb begin
    wrEn   = strb.capWr || strb.hostWrMem;
    wrAddr = strb.capWr ? capAddr : hostAddr;
    wrData = strb.capWr ? liveWord : hostWdata;
  end

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outWord   <= '0;
      hostRdata <= '0;
    end else begin
      case (strb.sel)
        SEL_MEM:  outWord <= mem[playAddr];
        SEL_ZERO: outWord <= '0;
        default:  outWord <= liveWord;
      endcase
      if (strb.hostRdMem)      hostRdata <= mem[hostAddr];
      else if (strb.hostRdReg) hostRdata <= {{(WORD_W-3){1'b0}}, regVal};
      else                     hostRdata <= '0;
    end
  end

  // R8: one writer at a time on the buffer port
  p_one_writer_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.capWr && strb.hostWrMem));

  // R6: zero fill outside the one-shot window
  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sel == SEL_ZERO) |=> (outWord == '0));

  // R2: live forwarding with one cycle of delay
  p_live_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sel == SEL_LIVE) |=> (outWord == $past(liveWord)));
endmodule

// File: rtl/linkReplayBuf.sv
`timescale 1ns/1ps
module linkReplayBuf
  import lrbPkg::*;
#(
  parameter int ENERGY_W  = 8,
  parameter int FEAT_W    = 4,
  parameter int ADDR_W    = 8,
  parameter int ORBIT_LEN = 3564,
  localparam int WORD_W   = ENERGY_W + FEAT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              orbitMark,
  input  logic [ENERGY_W-1:0] liveEnergy,
  input  logic [FEAT_W-1:0] liveFeat,
  output logic [ENERGY_W-1:0] outEnergy,
  output logic [FEAT_W-1:0] outFeat,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W:0]   hostAddr,
  input  logic [WORD_W-1:0] hostWdata,
  output logic [WORD_W-1:0] hostRdata,
  output logic              hostErr,
  output logic              captureDone
);
  lrbStrb_t          strb;
  logic [ADDR_W-1:0] capAddr, playAddr;
  logic [2:0]        regVal;
  logic [WORD_W-1:0] outWord;

  lrbCtrl #(.ADDR_W(ADDR_W), .ORBIT_LEN(ORBIT_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .orbitMark(orbitMark),
    .hostWr(hostWr), .hostRd(hostRd), .hostRegSel(hostAddr[ADDR_W]),
    .hostModeData(hostWdata[1:0]), .strb(strb), .capAddr(capAddr),
    .playAddr(playAddr), .regVal(regVal), .hostErr(hostErr),
    .capDone(captureDone)
  );

  lrbData #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .capAddr(capAddr),
    .playAddr(playAddr), .hostAddr(hostAddr[ADDR_W-1:0]),
    .hostWdata(hostWdata), .liveWord({liveFeat, liveEnergy}),
    .regVal(regVal), .outWord(outWord), .hostRdata(hostRdata)
  );

  assign outEnergy = outWord[ENERGY_W-1:0];
  assign outFeat   = outWord[WORD_W-1:ENERGY_W];
endmodule

// File: tb/linkReplayBuf_tb_top.sv
`timescale 1ns/1ps
module linkReplayBuf_tb_top;
  localparam int ORBIT = 3564;
  localparam int DEPTH = 256;
  localparam int WW    = 12;

  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          orbitMark = 0, hostWr = 0, hostRd = 0;
  logic [7:0]    liveEnergy = 0, outEnergy;
  logic [3:0]    liveFeat = 0, outFeat;
  logic [8:0]    hostAddr = 0;
  logic [WW-1:0] hostWdata = 0, hostRdata;
  logic          hostErr, captureDone;

  linkReplayBuf dut_i (
    .clk(clk), .rstN(rstN), .orbitMark(orbitMark),
    .liveEnergy(liveEnergy), .liveFeat(liveFeat),
    .outEnergy(outEnergy), .outFeat(outFeat),
    .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostErr(hostErr), .captureDone(captureDone)
  );

  int nChk = 0, nBad = 0;
  string tag = "R1", rdTag = "R8";
  logic [WW-1:0] expMem [DEPTH];
  int mMode = 0, mArmed = 0, mCapOn = 0, mCapIdx = 0, mDone = 0, mBx = 0;
  logic [WW-1:0] expOut = 0, expRd = 0;
  bit expErr = 0, rdPend = 0;

  task automatic chk(string t, string what, logic [WW-1:0] act, logic [WW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", t, what, act, exp, $time);
    end
  endtask

  function automatic logic [WW-1:0] playWord(int m, int bx, logic [WW-1:0] live);
    if (m == 2) return (bx < DEPTH) ? expMem[bx] : '0;
    if (m == 3) return expMem[bx % DEPTH];
    return live;
  endfunction

  task automatic cyc(bit mk, logic [WW-1:0] live, bit wr, bit rd, logic [8:0] a, logic [WW-1:0] d);
    int bxNow, addr;
    bit memAcc, capStart, capWr;
    @(negedge clk);
    chk(tag, "out", {outFeat, outEnergy}, expOut);
    chk("R9", "err", {11'd0, hostErr}, {11'd0, expErr});
    chk("R5", "done", {11'd0, captureDone}, WW'(mDone));
    if (rdPend) chk(rdTag, "rdata", hostRdata, expRd);
    orbitMark = mk; {liveFeat, liveEnergy} = live;
    hostWr = wr; hostRd = rd; hostAddr = a; hostWdata = d;
    bxNow    = mk ? 0 : mBx;
    memAcc   = (wr || rd) && !a[8];
    expOut   = playWord(mMode, bxNow, live);
    expErr   = memAcc && (mMode != 0);
    rdPend   = rd;
    rdTag    = a[8] ? "R10" : ((mMode == 0) ? "R8" : "R9");
    expRd    = !rd ? '0 : a[8] ? WW'({mDone[0], mMode[1:0]}) : ((mMode == 0) ? expMem[a[7:0]] : '0);
    capStart = (mMode == 1) && (mArmed != 0) && mk;
    capWr    = (mMode == 1) && (capStart || (mCapOn != 0));
    addr     = capStart ? 0 : mCapIdx;
    if (capWr) expMem[addr] = live;
    if (wr && !a[8] && mMode == 0) expMem[a[7:0]] = d;
    mBx = (bxNow == ORBIT - 1) ? 0 : bxNow + 1;
    if (wr && a[8]) begin
      mMode = int'(d[1:0]); mArmed = (d[1:0] == 2'd1); mDone = 0; mCapOn = 0; mCapIdx = 0;
    end else if (capWr) begin
      mArmed = 0;
      if (addr == DEPTH - 1) begin mCapOn = 0; mDone = 1; end
      else begin mCapOn = 1; mCapIdx = addr + 1; end
    end
  endtask

  function automatic logic [WW-1:0] rnd();
    return WW'($urandom);
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, rnd(), 0, 0, 0, 0);
  endtask

  task automatic setMode(int m, bit mk);
    cyc(mk, rnd(), 1, 0, 9'h100, WW'(m));
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd20417));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "out", {outFeat, outEnergy}, '0);
    chk("R1", "done", {11'd0, captureDone}, '0);
    chk("R1", "err", {11'd0, hostErr}, '0);
    rstN = 1'b1;
    tag = "R1";
    cyc(0, 0, 0, 1, 9'h100, 0);           // R10: mode reads as 0 after reset
    // R2: pass-through with random stimulus and sparse markers
    tag = "R2";
    for (int i = 0; i < 200; i++) cyc(($urandom % 50) == 0, rnd(), 0, 0, 0, 0);
    // R8: load the buffer, then read back at random
    tag = "R8";
    for (int i = 0; i < DEPTH; i++) cyc(0, rnd(), 1, 0, 9'(i), rnd());
    for (int i = 0; i < 40; i++) cyc(0, rnd(), 0, 1, 9'($urandom % DEPTH), 0);
    cyc(0, rnd(), 0, 1, 9'd0, 0);
    cyc(0, rnd(), 0, 1, 9'd255, 0);
    // R6: one-shot replay from a marker
    tag = "R10";
    setMode(2, 0);
    cyc(0, rnd(), 0, 1, 9'h100, 0);
    tag = "R6";
    cyc(1, rnd(), 0, 0, 0, 0);
    idle(600);
    // R3: counter wraps without a marker, replay restarts at crossing 0
    tag = "R3";
    idle(ORBIT);
    // R9: refused accesses while replaying; entry 5 must survive
    tag = "R9";
    cyc(0, rnd(), 1, 0, 9'd5, 12'hABC);
    cyc(0, rnd(), 0, 1, 9'd5, 0);
    cyc(1, rnd(), 0, 0, 0, 0);
    idle(300);
    // R7: looping replay, then a marker mid-loop realigns it
    tag = "R7";
    setMode(3, 0);
    cyc(1, rnd(), 0, 0, 0, 0);
    idle(700);
    cyc(1, rnd(), 0, 0, 0, 0);
    idle(400);
    // R4: arm recording; a marker in the arming cycle is ignored
    tag = "R4";
    setMode(0, 0);
    setMode(1, 1);
    idle(37);
    cyc(0, rnd(), 0, 1, 9'd7, 0);        // R9: read refused while recording
    cyc(1, rnd(), 0, 0, 0, 0);
    idle(300);
    // R5: later markers must not restart recording
    tag = "R5";
    cyc(1, rnd(), 0, 0, 0, 0);
    idle(300);
    cyc(0, rnd(), 0, 1, 9'h100, 0);      // R10: done bit and mode
    // R4: read back the recorded run
    tag = "R4";
    setMode(0, 0);
    for (int i = 0; i < DEPTH; i++) cyc(0, rnd(), 0, 1, 9'(i), 0);
    idle(2);
    report();
  end
endmodule